// File: doc/BRIEF.md
# Three-Level Neutral-Clamped Leg Gate Sequencer

This block drives the six gate enables of one phase leg of a three-level active neutral-point-clamped converter. It takes a single high-frequency PWM command and a line-polarity flag. In each half cycle it holds the matching slow inner switch on and runs the outer switch and its neutral clamp as a synchronous buck pair. During active intervals it also drives the opposite clamp switch, so the blocking voltage splits evenly across the idle inner and outer devices. Every PWM edge passes through a programmable dead interval. Every polarity change runs a fixed break-before-make handover of the slow switches.

A controller needs only two signals per leg, so three legs use six PWM lines. A fault input and a clear input let protection logic stop the leg at once and restart it under control. A built-in interlock stops any shoot-through pattern from reaching the pins.

Top module: `anpc_leg_seq`

## Requirements
- R1: In reset, and while the leg starts up afterwards, all six gates and `fault_o` are low. After reset is released, the gates stay low for D cycles, and then the slow switch of the sampled polarity turns on alone. D is `dead_cyc`, or 1 when `dead_cyc` is 0. Inputs are sampled on a rising edge, and the registered outputs change on that same edge.
- R2: With `pol_pos`=1 (positive half), `slow_hi` is on, and `slow_lo` and `outer_lo` stay off. The active state (PWM high) drives `outer_hi` with `clamp_lo`. The freewheel state (PWM low) drives `clamp_hi` only.
- R3: With `pol_pos`=0 (negative half), `slow_lo` is on, and `slow_hi` and `outer_hi` stay off. The active state drives `outer_lo` with `clamp_hi`. The freewheel state drives `clamp_lo` only.
- R4: A PWM change inside a half cycle first turns off all four fast gates (`outer_hi`, `outer_lo`, `clamp_hi`, `clamp_lo`) for exactly D cycles while the slow switch stays on. The next state then follows the PWM level sampled on the edge that ends that interval.
- R5: A polarity change runs this sequence. First, D cycles with all fast gates off and the old slow switch still on. Then D cycles with all gates off. Then D cycles with only the new slow switch on. PWM gating resumes only after that.
- R6: `outer_hi` and `outer_lo` are never on together, and neither are `slow_hi` and `slow_lo`. If the sequencer ever requests such a pattern, all six gates go off and the leg latches a fault.
- R7: If `trip_n` is sampled low, all six gates are off and `fault_o` is high from that same edge on.
- R8: A latched fault holds all gates off until `trip_clr` is sampled high while `pwm_in` is low and `trip_n` is high. A clear with `pwm_in` high has no effect. A valid clear drops `fault_o` and restarts the R1 start-up sequence.
- R9: With `dead_cyc` = 0, every dead interval and every handover step lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | 1 | High-frequency command: 1 = active, 0 = freewheel |
| pol_pos | input | 1 | Line polarity: 1 = positive half, 0 = negative half |
| trip_n | input | 1 | Fault request, active low |
| trip_clr | input | 1 | Fault clear request |
| dead_cyc | input | DT_W | Dead interval length in clock cycles (0 acts as 1) |
| outer_hi | output | 1 | Outer switch to positive rail |
| slow_hi | output | 1 | Slow inner switch, positive half |
| slow_lo | output | 1 | Slow inner switch, negative half |
| outer_lo | output | 1 | Outer switch to negative rail |
| clamp_hi | output | 1 | Neutral clamp, upper (positive freewheel / negative balance) |
| clamp_lo | output | 1 | Neutral clamp, lower (negative freewheel / positive balance) |
| fault_o | output | 1 | Latched fault |

## Verification
The bench targets several ways the leg could go wrong, each with a visible symptom:
- PWM pulses shorter than the dead interval. A design that dropped the end-of-interval resampling would enter the wrong state, or switch a clamp while its partner outer switch was still conducting.
- Polarity flips in the middle of an active interval. A wrong handover would show overlapping slow switches, or a fast gate firing before the new slow switch settles.
- A zero dead-interval setting. A design without the floor of one cycle would either skip the gap entirely or stall.
- A fault clear issued while PWM is high. A design that honoured it would restart the leg into a live pulse.

// File: rtl/anpc_pkg.sv
package anpc_pkg;

  typedef enum logic [2:0] {
    S_GAP   = 3'd0,  // every gate off, timed
    S_DRAIN = 3'd1,  // fast gates off, old slow switch held, timed
    S_DEAD  = 3'd2,  // fast gates off, slow switch on, timed
    S_ACT   = 3'd3,  // active pattern of the current half
    S_FW    = 3'd4,  // freewheel pattern of the current half
    S_TRIP  = 3'd5   // latched fault
  } leg_st_e;

  typedef struct packed {
    logic clamp_lo;
    logic clamp_hi;
    logic outer_lo;
    logic slow_lo;
    logic slow_hi;
    logic outer_hi;
  } gate_set_t;

  localparam int GATE_N = $bits(gate_set_t);

endpackage

// File: rtl/anpc_leg_fsm.sv
module anpc_leg_fsm
  import anpc_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwm_in,
  input  logic            pol_pos,
  input  logic            trip_n,
  input  logic            trip_clr,
  input  logic [DT_W-1:0] dead_cyc,
  input  logic            illegal,
  output leg_st_e         st_nx,
  output logic            pos_nx,
  output logic            fault_o
);

  localparam logic [DT_W-1:0] ONE = DT_W'(1);

  leg_st_e         st_q;
  logic            pos_q;
  logic [DT_W-1:0] cnt_q, cnt_nx;
  logic [DT_W-1:0] reload;
  logic            done, pol_bad;

  // a zero setting is floored to one cycle; counter holds cycles left minus one
  assign reload  = ((dead_cyc == '0) ? ONE : dead_cyc) - ONE;
  assign done    = (cnt_q == '0);
  assign pol_bad = (pol_pos != pos_q);

  always_comb begin
    st_nx  = st_q;
    pos_nx = pos_q;
    cnt_nx = cnt_q;
    if (!trip_n) begin
      st_nx = S_TRIP;
    end else begin
      unique case (st_q)
        S_TRIP: begin
          if (trip_clr && !pwm_in) begin
            st_nx  = S_GAP;
            cnt_nx = reload;
          end
        end
        S_GAP: begin
          if (done) begin
            st_nx  = S_DEAD;
            pos_nx = pol_pos;
            cnt_nx = reload;
          end else begin
            cnt_nx = cnt_q - ONE;
          end
        end
        S_DRAIN: begin
          if (done) begin
            st_nx  = S_GAP;
            cnt_nx = reload;
          end else begin
            cnt_nx = cnt_q - ONE;
          end
        end
        S_DEAD: begin
          if (pol_bad) begin
            st_nx  = S_DRAIN;
            cnt_nx = reload;
          end else if (done) begin
            st_nx = pwm_in ? S_ACT : S_FW;
          end else begin
            cnt_nx = cnt_q - ONE;
          end
        end
        S_ACT: begin
          if (pol_bad) begin
            st_nx  = S_DRAIN;
            cnt_nx = reload;
          end else if (!pwm_in) begin
            st_nx  = S_DEAD;
            cnt_nx = reload;
          end
        end
        S_FW: begin
          if (pol_bad) begin
            st_nx  = S_DRAIN;
            cnt_nx = reload;
          end else if (pwm_in) begin
            st_nx  = S_DEAD;
            cnt_nx = reload;
          end
        end
        default: st_nx = S_TRIP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= S_GAP;
      pos_q <= 1'b1;
      cnt_q <= reload;
    end else begin
      st_q  <= illegal ? S_TRIP : st_nx;
      pos_q <= pos_nx;
      cnt_q <= cnt_nx;
    end
  end

  assign fault_o = (st_q == S_TRIP);

  // R8: a fault with no valid clear stays latched
  a_r8_fault_holds: assert property (@(posedge clk) disable iff (rst)
    fault_o && !(trip_clr && !pwm_in && trip_n) |=> fault_o);

  // R7: a sampled trip always lands in the fault state
  a_r7_trip_latches: assert property (@(posedge clk) disable iff (rst)
    !trip_n |=> fault_o);

endmodule

// File: rtl/anpc_gate_map.sv
module anpc_gate_map
  import anpc_pkg::*;
#(
  parameter bit BALANCE_EN = 1'b1
) (
  input  leg_st_e   st,
  input  logic      pos,
  output gate_set_t want
);

  logic in_half, act, fw, bal;

  assign in_half = (st == S_DRAIN) || (st == S_DEAD) || (st == S_ACT) || (st == S_FW);
  assign act     = (st == S_ACT);
  assign fw      = (st == S_FW);

  generate
    if (BALANCE_EN) begin : g_bal
      assign bal = act;
    end else begin : g_nobal
      assign bal = 1'b0;
    end
  endgenerate

  always_comb begin
    want          = '0;
    want.slow_hi  = in_half & pos;
    want.slow_lo  = in_half & ~pos;
    want.outer_hi = act & pos;
    want.outer_lo = act & ~pos;
    want.clamp_hi = (fw & pos) | (bal & ~pos);
    want.clamp_lo = (fw & ~pos) | (bal & pos);
  end

endmodule

// File: rtl/anpc_interlock.sv
module anpc_interlock
  import anpc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  gate_set_t want,
  output gate_set_t q,
  output logic      illegal
);

  logic [GATE_N-1:0] want_v, q_v;

  assign want_v  = want;
  assign illegal = (want.outer_hi & want.outer_lo) | (want.slow_hi & want.slow_lo);

  generate
    for (genvar b = 0; b < GATE_N; b++) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q_v[b] <= 1'b0;
        else     q_v[b] <= want_v[b] & ~illegal;
      end
    end
  endgenerate

  assign q = gate_set_t'(q_v);

  // R6: no shoot-through pair on the pins
  a_r6_no_shoot: assert property (@(posedge clk) disable iff (rst)
    !(q.outer_hi && q.outer_lo) && !(q.slow_hi && q.slow_lo));

  // R2: positive outer switch only inside a positive half
  a_r2_outer_hi_half: assert property (@(posedge clk) disable iff (rst)
    q.outer_hi |-> q.slow_hi && !q.slow_lo);

  // R3: negative outer switch only inside a negative half
  a_r3_outer_lo_half: assert property (@(posedge clk) disable iff (rst)
    q.outer_lo |-> q.slow_lo && !q.slow_hi);

  // R4: outer and synchronous clamp of one half never hand over directly
  a_r4_outer_after_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(q.outer_hi) |-> !$past(q.clamp_hi));

  a_r4_clamp_after_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(q.clamp_hi) && q.slow_hi |-> !$past(q.outer_hi));

endmodule

// File: rtl/anpc_leg_seq.sv
module anpc_leg_seq
  import anpc_pkg::*;
#(
  parameter int DT_W       = 8,
  parameter bit BALANCE_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwm_in,
  input  logic            pol_pos,
  input  logic            trip_n,
  input  logic            trip_clr,
  input  logic [DT_W-1:0] dead_cyc,
  output logic            outer_hi,
  output logic            slow_hi,
  output logic            slow_lo,
  output logic            outer_lo,
  output logic            clamp_hi,
  output logic            clamp_lo,
  output logic            fault_o
);

  leg_st_e   st_nx;
  logic      pos_nx;
  logic      illegal;
  gate_set_t want, gq;

  anpc_leg_fsm #(.DT_W(DT_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .pwm_in   (pwm_in),
    .pol_pos  (pol_pos),
    .trip_n   (trip_n),
    .trip_clr (trip_clr),
    .dead_cyc (dead_cyc),
    .illegal  (illegal),
    .st_nx    (st_nx),
    .pos_nx   (pos_nx),
    .fault_o  (fault_o)
  );

  anpc_gate_map #(.BALANCE_EN(BALANCE_EN)) u_map (
    .st   (st_nx),
    .pos  (pos_nx),
    .want (want)
  );

  anpc_interlock u_lock (
    .clk     (clk),
    .rst     (rst),
    .want    (want),
    .q       (gq),
    .illegal (illegal)
  );

  assign outer_hi = gq.outer_hi;
  assign slow_hi  = gq.slow_hi;
  assign slow_lo  = gq.slow_lo;
  assign outer_lo = gq.outer_lo;
  assign clamp_hi = gq.clamp_hi;
  assign clamp_lo = gq.clamp_lo;

  // R7: a trip clears every gate on the next edge
  a_r7_all_off: assert property (@(posedge clk) disable iff (rst)
    !trip_n |=> !(outer_hi || slow_hi || slow_lo || outer_lo || clamp_hi || clamp_lo));

  // R5: an old slow switch only opens after the fast gates are already off
  a_r5_slow_break: assert property (@(posedge clk) disable iff (rst)
    $fell(slow_hi) && !fault_o |-> $past(!outer_hi && !clamp_hi && !clamp_lo));

  // R5: a new slow switch never follows the other slow switch directly
  a_r5_slow_make: assert property (@(posedge clk) disable iff (rst)
    $rose(slow_lo) |-> !$past(slow_hi));

endmodule

// File: tb/tb_anpc_leg_seq.sv
module tb_anpc_leg_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwm_in = 1'b0, pol_pos = 1'b1, trip_n = 1'b1, trip_clr = 1'b0;
  logic [7:0] dead_cyc = 8'd3;
  logic       outer_hi, slow_hi, slow_lo, outer_lo, clamp_hi, clamp_lo, fault_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit run_cmp = 1'b0;

  always #5 clk = ~clk;

  anpc_leg_seq dut (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .pol_pos(pol_pos), .trip_n(trip_n),
    .trip_clr(trip_clr), .dead_cyc(dead_cyc), .outer_hi(outer_hi), .slow_hi(slow_hi),
    .slow_lo(slow_lo), .outer_lo(outer_lo), .clamp_hi(clamp_hi), .clamp_lo(clamp_lo),
    .fault_o(fault_o)
  );

  // bit order: {clamp_lo, clamp_hi, outer_lo, slow_lo, slow_hi, outer_hi}
  wire [5:0] g = {clamp_lo, clamp_hi, outer_lo, slow_lo, slow_hi, outer_hi};

  // reference model: modes 0 gap, 1 drain, 2 dead, 3 act, 4 fw, 5 trip
  int m_mode = 0, m_left = 1;
  bit m_pos = 1'b1;

  always @(posedge clk) begin
    int d;
    d = (dead_cyc == 0) ? 1 : int'(dead_cyc);
    if (rst) begin
      m_mode = 0; m_left = d; m_pos = 1'b1;
    end else if (!trip_n) begin
      m_mode = 5;
    end else begin
      case (m_mode)
        5: if (trip_clr && !pwm_in) begin m_mode = 0; m_left = d; end
        0: if (m_left <= 1) begin m_mode = 2; m_pos = pol_pos; m_left = d; end
           else m_left--;
        1: if (m_left <= 1) begin m_mode = 0; m_left = d; end
           else m_left--;
        2: if (pol_pos != m_pos) begin m_mode = 1; m_left = d; end
           else if (m_left <= 1) m_mode = pwm_in ? 3 : 4;
           else m_left--;
        3: if (pol_pos != m_pos) begin m_mode = 1; m_left = d; end
           else if (!pwm_in) begin m_mode = 2; m_left = d; end
        default: if (pol_pos != m_pos) begin m_mode = 1; m_left = d; end
                 else if (pwm_in) begin m_mode = 2; m_left = d; end
      endcase
    end
  end

  function automatic logic [5:0] exp_gates();
    logic [5:0] e;
    e = 6'b0;
    if (m_mode >= 1 && m_mode <= 4) e[m_pos ? 1 : 2] = 1'b1;
    if (m_mode == 3) begin
      if (m_pos) begin e[0] = 1'b1; e[5] = 1'b1; end
      else       begin e[3] = 1'b1; e[4] = 1'b1; end
    end
    if (m_mode == 4) e[m_pos ? 4 : 5] = 1'b1;
    return e;
  endfunction

  task automatic chk(input string tag, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (run_cmp && !rst) begin
      string tag;
      case (m_mode)
        0, 1: tag = "R5";
        2:    tag = "R4";
        5:    tag = "R7";
        default: tag = m_pos ? "R2" : "R3";
      endcase
      chk(tag, {fault_o, g}, {(m_mode == 5), exp_gates()});
      checks++;  // R6 shoot-through watch
      if ((outer_hi && outer_lo) || (slow_hi && slow_lo)) begin
        errors++;
        $display("FAIL R6 got %b expected no shoot-through pair", g);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulses();
    int hi[5] = '{10, 2, 1, 6, 4};
    int lo[5] = '{7, 1, 3, 9, 2};
    for (int k = 0; k < 5; k++) begin
      pwm_in = 1'b1; tick(hi[k]);
      pwm_in = 1'b0; tick(lo[k]);
    end
  endtask

  initial begin
    tick(4);
    chk("R1", {fault_o, g}, 7'b0);
    rst = 1'b0;
    run_cmp = 1'b1;
    tick(2);
    chk("R1", {fault_o, g}, 7'b0);
    tick(1);
    chk("R1", {fault_o, g}, 7'b0000010);
    tick(3);
    pulses();
    pwm_in = 1'b1; tick(8);
    // R5: flip polarity in the middle of an active interval, D = 3
    pol_pos = 1'b0;
    for (int i = 0; i < 9; i++) begin
      tick(1);
      chk("R5", {fault_o, g}, (i < 3) ? 7'b0000010 : (i < 6) ? 7'b0 : 7'b0000100);
    end
    tick(4);
    chk("R3", {fault_o, g}, 7'b0011100);
    pulses();
    pol_pos = 1'b1; tick(12);
    pulses();
    // R9: zero setting acts as a one-cycle interval
    dead_cyc = 8'd0;
    pol_pos = 1'b0; pwm_in = 1'b0; tick(10);
    chk("R3", {fault_o, g}, 7'b0100100);
    pwm_in = 1'b1; tick(1);
    chk("R9", {fault_o, g}, 7'b0000100);
    tick(1);
    chk("R9", {fault_o, g}, 7'b0011100);
    pulses();
    dead_cyc = 8'd5;
    pol_pos = 1'b1; tick(20);
    pwm_in = 1'b1; tick(8);
    // R7 / R8: trip, ignored clear, valid clear
    trip_n = 1'b0; tick(1);
    chk("R7", {fault_o, g}, 7'b1000000);
    trip_n = 1'b1; trip_clr = 1'b1; tick(3);
    chk("R8", {fault_o, g}, 7'b1000000);
    pwm_in = 1'b0; tick(1);
    chk("R8", {fault_o, g}, 7'b0);
    trip_clr = 1'b0; tick(12);
    chk("R8", {fault_o, g}, 7'b0010010);
    pulses();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule